// File: doc/BRIEF.md
# Burst Column Address Generator

This block supplies the column address for each data beat of a synchronous DRAM read or write burst. A start strobe carries the first column and a read/write flag. The block then steps through the burst in the order the mode settings select: sequential or interleaved wrap, with a length of 1, 2, 4 or 8 beats, or a full-page sweep of the whole row. Each beat comes with a valid flag, and the final beat also raises a last flag.

The first beat comes out in the same cycle as the start strobe. The block accepts a new start on any clock, and that start abandons the burst in progress. A terminate strobe cuts a burst short. Full-page bursts run until such a strobe arrives. A write-single option makes writes move one beat while reads keep the programmed length. The mode inputs are sampled on the start strobe.

Top module: `burst_col_gen`

## Requirements
- R1: `bl_sel` selects the burst length as 0 = 1 beat, 1 = 2 beats, 2 = 4 beats, 3 = 8 beats. `beat_valid` is high for exactly that many consecutive cycles, and `beat_last` is high only on the final one.
- R2: In the cycle `start` is high, `beat_valid` is high and `col` equals `start_col`.
- R3: With `interleave` = 0, beat n of a fixed burst of length L has low log2(L) bits equal to (start low bits + n) mod L. The bits above them equal those of `start_col`.
- R4: With `interleave` = 1, beat n of a fixed burst has low log2(L) bits equal to the start low bits XOR n. The upper bits stay fixed.
- R5: With `full_page` = 1, `col` rises by one every cycle and wraps modulo 2^COL_W (256 by default). It keeps going until `stop` is high. `beat_last` is high in the `stop` cycle and the block is idle afterwards.
- R6: `full_page` = 1 together with `interleave` = 1 behaves as a sequential full-page burst.
- R7: A `start` during a burst abandons the old burst at once. A new burst begins from the new column in that cycle.
- R8: With `wr_single` = 1, a start with `start_wr` = 1 gives a single beat (`beat_valid` and `beat_last` both high in the start cycle). Reads keep the programmed length. With `wr_single` = 0, writes keep the programmed length too.
- R9: A one-beat burst raises `beat_valid` and `beat_last` together in the start cycle, and the block is idle in the next cycle.
- R10: While reset is active and after it is released, `beat_valid` and `beat_last` are low until the first `start`.
- R11: `stop` during a fixed-length burst ends it: that beat is valid and last, and the block is idle next. `stop` while idle, or in the same cycle as `start`, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst this cycle |
| start_col | input | COL_W | First column of the burst |
| start_wr | input | 1 | 1 = write burst, 0 = read burst |
| stop | input | 1 | Terminate the burst in progress |
| bl_sel | input | 2 | Burst length code (R1) |
| full_page | input | 1 | Full-page sequential burst |
| interleave | input | 1 | 1 = interleaved wrap, 0 = sequential |
| wr_single | input | 1 | Writes move one beat |
| col | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | A beat is issued this cycle |
| beat_last | output | 1 | This beat ends the burst |

## Verification
The assertions assume that `full_page` does not change while a burst is running, except in the cycle of a new `start`. The block samples its mode at the start strobe, but the properties read the live input. The stimulus changes mode inputs only in a cycle where `start` is high or the block is idle. Preemption tests change only the burst length. The reset property assumes that `start` stays low while reset is held, and the bench keeps it low.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_wr,
  input  logic             stop,
  input  logic [1:0]       bl_sel,
  input  logic             full_page,
  input  logic             interleave,
  input  logic             wr_single,
  output logic [COL_W-1:0] col,
  output logic             beat_valid,
  output logic             beat_last
);

  logic             act_q, il_q, fp_q;
  logic [COL_W-1:0] base_q, cnt_q, msk_q;

  logic             one_beat, il_new, fp_new;
  logic [COL_W-1:0] msk_new;

  assign one_beat = start_wr & wr_single;
  assign fp_new   = full_page & ~one_beat;
  assign il_new   = interleave & ~full_page;
  assign msk_new  = one_beat  ? '0 :
                    full_page ? '1 :
                    (COL_W'(1) << bl_sel) - COL_W'(1);

  logic [COL_W-1:0] cur_b, cur_n, cur_m;
  logic             cur_il, cur_fp, cut;

  assign cur_b  = start ? start_col : base_q;
  assign cur_n  = start ? '0        : cnt_q;
  assign cur_m  = start ? msk_new   : msk_q;
  assign cur_il = start ? il_new    : il_q;
  assign cur_fp = start ? fp_new    : fp_q;
  assign cut    = stop & ~start;

  assign col = cur_il ? (cur_b ^ cur_n)
                      : ((cur_b & ~cur_m) | ((cur_b + cur_n) & cur_m));

  assign beat_valid = start | act_q;
  assign beat_last  = beat_valid & (cut | (~cur_fp & (cur_n == cur_m)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      il_q   <= 1'b0;
      fp_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      msk_q  <= '0;
    end else if (start) begin
      act_q  <= ~beat_last;
      il_q   <= il_new;
      fp_q   <= fp_new;
      base_q <= start_col;
      cnt_q  <= COL_W'(1);
      msk_q  <= msk_new;
    end else if (act_q) begin
      act_q  <= ~beat_last;
      cnt_q  <= cnt_q + COL_W'(1);
    end
  end

endmodule

module burst_col_gen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic             start_wr,
  input logic             stop,
  input logic             full_page,
  input logic             wr_single,
  input logic [COL_W-1:0] col,
  input logic             beat_valid,
  input logic             beat_last
);

  always_comb begin
    if (!rst_n) AST_IDLE_IN_RESET: assert (!beat_valid && !beat_last); // R10
  end

  AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid); // R1

  AST_START_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (beat_valid && col == start_col)); // R2

  AST_BURST_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last) |=> beat_valid); // R1

  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |=> (beat_valid == start)); // R9

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last && !full_page) |=>
      (start || col[COL_W-1:3] == $past(col[COL_W-1:3]))); // R3

  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last && full_page) |=>
      (start || col == $past(col) + COL_W'(1))); // R5

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start && beat_valid) |-> beat_last); // R11

  AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_wr && wr_single) |-> beat_last); // R8

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
  .start_wr(start_wr), .stop(stop), .full_page(full_page),
  .wr_single(wr_single), .col(col), .beat_valid(beat_valid),
  .beat_last(beat_last)
);

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, start_wr = 1'b0, stop = 1'b0;
  logic [7:0] start_col = '0;
  logic [1:0] bl_sel = '0;
  logic       full_page = 1'b0, interleave = 1'b0, wr_single = 1'b0;
  logic [7:0] col;
  logic       beat_valid, beat_last;

  int n_chk = 0, n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  burst_col_gen #(.COL_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .start_wr(start_wr), .stop(stop), .bl_sel(bl_sel), .full_page(full_page),
    .interleave(interleave), .wr_single(wr_single), .col(col),
    .beat_valid(beat_valid), .beat_last(beat_last)
  );

  task automatic chk(input logic ev, input logic el, input logic [7:0] ec, input string tag);
    n_chk++;
    if (beat_valid !== ev || beat_last !== el || (ev && col !== ec)) begin
      n_fail++;
      $display("FAIL %s: valid/last/col = %b/%b/%h, expected %b/%b/%h",
               tag, beat_valid, beat_last, col, ev, el, ec);
    end
  endtask

  function automatic logic [7:0] exp_col(input logic [7:0] s, input int n, input int len, input logic il);
    logic [7:0] m = 8'(len - 1);
    if (il) return s ^ 8'(n);
    return (s & ~m) | ((s + 8'(n)) & m);
  endfunction

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    #1 chk(1'b0, 1'b0, 8'h00, "R10 in reset");
    @(negedge clk) rst_n = 1'b1;
    #1 chk(1'b0, 1'b0, 8'h00, "R10 after reset");
  endtask

  task automatic t_burst(input logic [1:0] b, input logic il, input logic [7:0] s,
                         input logic wr, input logic wrs, input string tag);
    int len = (wr && wrs) ? 1 : (1 << b);
    @(negedge clk);
    bl_sel = b; interleave = il; full_page = 1'b0; wr_single = wrs;
    start = 1'b1; start_col = s; start_wr = wr;
    #1 chk(1'b1, len == 1, s, {tag, " beat0 R2"});
    for (int n = 1; n < len; n++) begin
      @(negedge clk) start = 1'b0;
      #1 chk(1'b1, n == len - 1, exp_col(s, n, len, il), tag);
    end
    @(negedge clk) start = 1'b0;
    #1 chk(1'b0, 1'b0, 8'h00, {tag, " idle after R1"});
  endtask

  task automatic t_page(input logic [7:0] s, input int beats, input logic il, input string tag);
    @(negedge clk);
    full_page = 1'b1; interleave = il; wr_single = 1'b0;
    start = 1'b1; start_col = s; start_wr = 1'b0;
    #1 chk(1'b1, 1'b0, s, {tag, " beat0"});
    for (int n = 1; n < beats; n++) begin
      @(negedge clk) start = 1'b0; stop = (n == beats - 1);
      #1 chk(1'b1, n == beats - 1, s + 8'(n), tag);
    end
    @(negedge clk) stop = 1'b0; full_page = 1'b0; interleave = 1'b0;
    #1 chk(1'b0, 1'b0, 8'h00, {tag, " idle after stop"});
  endtask

  task automatic t_preempt;
    @(negedge clk);
    bl_sel = 2'd3; interleave = 1'b0; start = 1'b1; start_col = 8'h10; start_wr = 1'b0;
    #1 chk(1'b1, 1'b0, 8'h10, "R7 first burst");
    for (int n = 1; n < 3; n++) begin
      @(negedge clk) start = 1'b0;
      #1 chk(1'b1, 1'b0, 8'h10 + 8'(n), "R7 first burst");
    end
    @(negedge clk) bl_sel = 2'd2; start = 1'b1; start_col = 8'h47;
    #1 chk(1'b1, 1'b0, 8'h47, "R7 preempt start");
    for (int n = 1; n < 4; n++) begin
      @(negedge clk) start = 1'b0;
      #1 chk(1'b1, n == 3, exp_col(8'h47, n, 4, 1'b0), "R7 new burst");
    end
    @(negedge clk);
    #1 chk(1'b0, 1'b0, 8'h00, "R7 idle");
  endtask

  task automatic t_stop;
    @(negedge clk) stop = 1'b1;
    #1 chk(1'b0, 1'b0, 8'h00, "R11 stop while idle");
    @(negedge clk) stop = 1'b0;
    bl_sel = 2'd3; start = 1'b1; start_col = 8'h20; start_wr = 1'b1; wr_single = 1'b0;
    #1 chk(1'b1, 1'b0, 8'h20, "R11 start");
    @(negedge clk) start = 1'b0;
    #1 chk(1'b1, 1'b0, 8'h21, "R11 beat1");
    @(negedge clk) stop = 1'b1;
    #1 chk(1'b1, 1'b1, 8'h22, "R11 stopped beat");
    @(negedge clk) stop = 1'b0;
    #1 chk(1'b0, 1'b0, 8'h00, "R11 idle after stop");
    @(negedge clk) bl_sel = 2'd1; start = 1'b1; stop = 1'b1; start_col = 8'h3A;
    #1 chk(1'b1, 1'b0, 8'h3A, "R11 stop with start ignored");
    @(negedge clk) start = 1'b0; stop = 1'b0;
    #1 chk(1'b1, 1'b1, 8'h3B, "R11 burst survives");
    @(negedge clk) start_wr = 1'b0;
    #1 chk(1'b0, 1'b0, 8'h00, "R11 idle");
  endtask

  initial begin
    #(PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_burst(2'd0, 1'b0, 8'h5C, 1'b0, 1'b0, "R1 R9 BL1");
    t_burst(2'd1, 1'b0, 8'h5D, 1'b0, 1'b0, "R1 R3 BL2 seq");
    t_burst(2'd2, 1'b0, 8'h2D, 1'b0, 1'b0, "R3 BL4 seq");
    t_burst(2'd3, 1'b0, 8'hC6, 1'b0, 1'b0, "R3 BL8 seq");
    t_burst(2'd2, 1'b1, 8'h9E, 1'b0, 1'b0, "R4 BL4 ilv");
    t_burst(2'd3, 1'b1, 8'h35, 1'b0, 1'b0, "R4 BL8 ilv");
    t_burst(2'd3, 1'b0, 8'h71, 1'b1, 1'b1, "R8 single write");
    t_burst(2'd2, 1'b0, 8'h72, 1'b0, 1'b1, "R8 read keeps length");
    t_burst(2'd1, 1'b1, 8'h73, 1'b1, 1'b0, "R8 write bursts");
    t_page(8'hFC, 10, 1'b0, "R5 page wrap");
    t_page(8'h43, 5, 1'b1, "R6 page ilv as seq");
    t_preempt();
    t_stop();
    summary();
    $finish;
  end
endmodule